// File: doc/BRIEF.md
# Dual-Mode Fingerprint Counter Word

This block is a 32-bit word with two uses. In storage mode it holds the block counter of a stream cipher: a host writes the value and reads it back unchanged. In fingerprint mode the same word returns a 32-bit device-unique response. Each response bit is taken from one of two fingerprint cell banks, and the challenge bit with the same index picks the bank. The power-up value of every cell is modelled by two 32-bit parameters, so two instances with different parameters stand for two different devices.

A small state machine controls the word and has four states. `ST_STORE` is storage mode with the output valid. `ST_FPRINT` is fingerprint mode with the output valid. `ST_CFG_STORE` and `ST_CFG_FPRINT` are configuration states that each last one cycle; the output is invalid while the machine is in either of them.

The machine moves between states as follows:
- Storage to fingerprint: `ST_STORE` goes to `ST_CFG_FPRINT` when `fp_mode` is high.
- Storage reconfigure: `ST_STORE` goes to `ST_CFG_STORE` when `cfg_strobe` is high and `fp_mode` is low.
- Fingerprint to storage: `ST_FPRINT` goes to `ST_CFG_STORE` when `fp_mode` is low.
- New challenge: `ST_FPRINT` goes to `ST_CFG_FPRINT` when `cfg_strobe` is high and `fp_mode` is high.
- Leaving configuration: `ST_CFG_STORE` always goes to `ST_STORE` on the next cycle, and `ST_CFG_FPRINT` always goes to `ST_FPRINT`. The challenge is latched during the `ST_CFG_FPRINT` cycle.

Top module: `dual_mode_puf_counter`

## Requirements
- R1: After reset the block is in storage mode, `word_out` is 0 and `word_valid` is 1.
- R2: In storage mode, a cycle with `wr_en` high loads `wr_data`, and the new value appears on `word_out` after that clock edge. A cycle with `wr_en` low leaves the stored value unchanged.
- R3: Raising `fp_mode` in storage mode gives exactly one cycle with `word_valid` 0 and `word_out` 0. On the following cycle `word_valid` is 1 and `word_out` shows the response.
- R4: In fingerprint mode, bit i of `word_out` equals bit i of parameter `BANK_ONE` when bit i of the latched challenge is 1. Otherwise it equals bit i of parameter `BANK_ZERO`.
- R5: In fingerprint mode, a `cfg_strobe` pulse gives one invalid cycle and latches the challenge present during that cycle.
- R6: Writes made outside the storage state are ignored. The counter value written before fingerprint mode is still held after the return to storage mode.
- R7: Lowering `fp_mode` in fingerprint mode gives exactly one invalid cycle. After it `word_out` shows the held counter.
- R8: A `cfg_strobe` pulse in storage mode gives one invalid cycle and leaves the counter unchanged.
- R9: While the block stays in fingerprint mode with no strobe, changes on `challenge` do not alter `word_out`.
- R10: Two instances with different bank parameters return different responses for the same challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_mode | input | 1 | 1 selects fingerprint mode, 0 selects storage mode |
| challenge | input | 32 | Branch select, one bit per response bit |
| wr_data | input | 32 | Counter value to store |
| wr_en | input | 1 | Write enable for storage mode |
| cfg_strobe | input | 1 | Requests a configuration cycle in the current mode |
| word_out | output | 32 | Stored counter or fingerprint response; 0 while invalid |
| word_valid | output | 1 | 1 when `word_out` is valid |

## Verification
The response path is exercised with four kinds of challenge:
- All zeros and all ones, which separate the two banks as whole words.
- All 32 walking-one patterns, which show that each challenge bit selects only its own response bit.
- A run of arithmetic pseudo-random words, which mix both banks across the word.

The counter path is tested with the following sequences:
- Writes with `wr_en` low and writes made during fingerprint mode, which show that these writes are ignored.
- Mode round trips, which confirm that the counter survives a visit to fingerprint mode.
- Challenge changes made without a strobe, which show that the response is latched and not combinational.

A second instance with different bank parameters is driven with the same challenges to show that its response differs.

// File: rtl/puf_word_pkg.sv
package puf_word_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_STORE      = 2'd0,
        ST_CFG_STORE  = 2'd1,
        ST_CFG_FPRINT = 2'd2,
        ST_FPRINT     = 2'd3
    } word_state_t;
endpackage

// File: rtl/puf_mode_fsm.sv
module puf_mode_fsm
    import puf_word_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fp_mode,
    input  logic cfg_strobe,
    output logic in_store,
    output logic in_fprint,
    output logic capture,
    output logic valid
);
    word_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STORE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STORE: begin
                if (fp_mode)         state_d = ST_CFG_FPRINT;
                else if (cfg_strobe) state_d = ST_CFG_STORE;
            end
            ST_FPRINT: begin
                if (!fp_mode)        state_d = ST_CFG_STORE;
                else if (cfg_strobe) state_d = ST_CFG_FPRINT;
            end
            ST_CFG_STORE:  state_d = ST_STORE;
            ST_CFG_FPRINT: state_d = ST_FPRINT;
            default:       state_d = ST_STORE;
        endcase
    end

    always_comb begin
        in_store  = 1'b0;
        in_fprint = 1'b0;
        capture   = 1'b0;
        valid     = 1'b0;
        unique case (state_q)
            ST_STORE:      begin in_store = 1'b1; valid = 1'b1; end
            ST_FPRINT:     begin in_fprint = 1'b1; valid = 1'b1; end
            ST_CFG_FPRINT: capture = 1'b1;
            ST_CFG_STORE:  ;
            default:       ;
        endcase
    end

    assert_enter_fprint_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_store && fp_mode) |=> (!valid && capture));
    assert_cfg_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> valid);
    assert_leave_fprint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fprint && !fp_mode) |=> (!valid ##1 in_store));
    assert_store_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_store && !fp_mode && cfg_strobe) |=> (!valid && !capture));
    assert_one_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_store, in_fprint, capture}));
endmodule

// File: rtl/puf_cell_bank.sv
module puf_cell_bank #(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] BANK_ZERO = 32'h6D2B_79F4,
    parameter logic [31:0] BANK_ONE  = 32'h91C4_0E3B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] challenge,
    output logic [WIDTH-1:0] response
);
    logic [WIDTH-1:0] pick;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign pick[i] = challenge[i] ? BANK_ONE[i] : BANK_ZERO[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       response <= '0;
        else if (capture) response <= pick;
    end

    assert_hold_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(response));
    assert_branch_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (response == (($past(challenge) & BANK_ONE[WIDTH-1:0]) |
                                  (~$past(challenge) & BANK_ZERO[WIDTH-1:0]))));
endmodule

// File: rtl/counter_store.sv
module counter_store #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_store,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count_q
);
    logic accept;
    assign accept = in_store && wr_en;

    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (accept) count_q <= wr_data;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_store && wr_en) |=> (count_q == $past(wr_data)));
    assert_no_stray_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_store && wr_en) |=> $stable(count_q));
endmodule

// File: rtl/dual_mode_puf_counter.sv
module dual_mode_puf_counter
    import puf_word_pkg::*;
#(
    parameter logic [31:0] BANK_ZERO = 32'h6D2B_79F4,
    parameter logic [31:0] BANK_ONE  = 32'h91C4_0E3B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fp_mode,
    input  logic [31:0] challenge,
    input  logic [31:0] wr_data,
    input  logic        wr_en,
    input  logic        cfg_strobe,
    output logic [31:0] word_out,
    output logic        word_valid
);
    logic in_store, in_fprint, capture;
    logic [WORD_W-1:0] count_q, response;

    puf_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fp_mode(fp_mode), .cfg_strobe(cfg_strobe),
        .in_store(in_store), .in_fprint(in_fprint), .capture(capture),
        .valid(word_valid)
    );

    counter_store #(.WIDTH(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .in_store(in_store), .wr_en(wr_en),
        .wr_data(wr_data), .count_q(count_q)
    );

    puf_cell_bank #(.WIDTH(WORD_W), .BANK_ZERO(BANK_ZERO), .BANK_ONE(BANK_ONE)) u_bank (
        .clk(clk), .rst_n(rst_n), .capture(capture), .challenge(challenge),
        .response(response)
    );

    always_comb begin
        word_out = '0;
        if (in_store)       word_out = count_q;
        else if (in_fprint) word_out = response;
    end

    assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> (word_out == '0));
    assert_counter_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fprint && !wr_en) |=> (in_fprint || capture || $stable(count_q)));
endmodule

// File: tb/test_dual_mode_puf_counter.sv
module test_dual_mode_puf_counter;
    localparam logic [31:0] A0 = 32'hC3A5_1E69;
    localparam logic [31:0] B0 = 32'h5A0F_96E1;
    localparam logic [31:0] A1 = 32'h0F1E_2D3C;
    localparam logic [31:0] B1 = 32'hE4D3_C2B1;

    logic clk = 0;
    logic rst_n = 0;
    logic fp_mode = 0, wr_en = 0, cfg_strobe = 0;
    logic [31:0] challenge = '0, wr_data = '0;
    logic [31:0] word_out, word_out_b;
    logic word_valid, word_valid_b;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_mode_puf_counter #(.BANK_ZERO(A0), .BANK_ONE(B0)) i_dual_mode_puf_counter (
        .clk(clk), .rst_n(rst_n), .fp_mode(fp_mode), .challenge(challenge),
        .wr_data(wr_data), .wr_en(wr_en), .cfg_strobe(cfg_strobe),
        .word_out(word_out), .word_valid(word_valid));

    dual_mode_puf_counter #(.BANK_ZERO(A1), .BANK_ONE(B1)) i_dual_mode_puf_counter_b (
        .clk(clk), .rst_n(rst_n), .fp_mode(fp_mode), .challenge(challenge),
        .wr_data(wr_data), .wr_en(wr_en), .cfg_strobe(cfg_strobe),
        .word_out(word_out_b), .word_valid(word_valid_b));

    function automatic logic [31:0] expect_resp(logic [31:0] c, logic [31:0] a, logic [31:0] b);
        return (c & b) | (~c & a);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic enter_fprint(logic [31:0] c, string req);
        fp_mode = 1; challenge = c;
        tick();
        check(req, {word_valid, word_out}, {1'b0, 32'h0});
        tick();
        check(req, {word_valid, word_out}, {1'b1, expect_resp(c, A0, B0)});
    endtask

    task automatic restrobe(logic [31:0] c, string req);
        challenge = c; cfg_strobe = 1;
        tick();
        cfg_strobe = 0;
        check(req, {word_valid, word_out}, {1'b0, 32'h0});
        tick();
        check(req, {word_valid, word_out}, {1'b1, expect_resp(c, A0, B0)});
    endtask

    task automatic leave_fprint(logic [31:0] held, string req);
        fp_mode = 0;
        tick();
        check(req, {word_valid, word_out}, {1'b0, 32'h0});
        tick();
        check(req, {word_valid, word_out}, {1'b1, held});
    endtask

    initial begin
        logic [31:0] lcg;
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R1", {word_valid, word_out}, {1'b1, 32'h0});

        wr_data = 32'h1234_5678; wr_en = 1; tick(); wr_en = 0;
        check("R2", {word_valid, word_out}, {1'b1, 32'h1234_5678});
        wr_data = 32'hDEAD_BEEF; tick();
        check("R2 no enable", {word_valid, word_out}, {1'b1, 32'h1234_5678});
        wr_data = 32'h0000_0007; wr_en = 1; tick(); wr_en = 0;
        check("R2", {word_valid, word_out}, {1'b1, 32'h0000_0007});

        cfg_strobe = 1; tick(); cfg_strobe = 0;
        check("R8", {word_valid, word_out}, {1'b0, 32'h0});
        tick();
        check("R8", {word_valid, word_out}, {1'b1, 32'h0000_0007});

        enter_fprint(32'h0000_0000, "R3 R4 zeros");
        restrobe(32'hFFFF_FFFF, "R5 R4 ones");
        for (int i = 0; i < 32; i++) restrobe(32'h1 << i, "R4 walking");
        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            restrobe(lcg, "R4 R5 mixed");
            checks++;
            if (word_out_b === word_out) begin
                errors++;
                $display("FAIL R10 actual=%h expected!=%h", word_out_b, word_out);
            end
        end

        challenge = 32'hA5A5_A5A5; wr_data = 32'hFFFF_0000; wr_en = 1;
        tick(); tick();
        wr_en = 0;
        check("R9 R6", {word_valid, word_out}, {1'b1, expect_resp(lcg, A0, B0)});

        leave_fprint(32'h0000_0007, "R7 R6");

        enter_fprint(32'h0F0F_0F0F, "R3");
        wr_data = 32'h7777_7777; wr_en = 1; fp_mode = 0;
        tick();
        check("R6 cfg", {word_valid, word_out}, {1'b0, 32'h0});
        wr_en = 0; tick();
        check("R6 R7", {word_valid, word_out}, {1'b1, 32'h0000_0007});

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule